// File: doc/BRIEF.md
# Filtered Quadrature Position Decoder

This block turns two asynchronous phase signals from an incremental encoder into a position count. Each phase is brought into the clock domain by a two-flop synchronizer, then cleaned by a digital glitch filter whose length is set separately for each phase. An optional per-phase inversion follows the filter. The cleaned phases feed a step decoder, and its steps move a position counter that wraps at a programmable modulo value.

Two decoding schemes are available. In the phase-encoded scheme every valid edge of either phase is one step, and the phase order sets the direction. In the step-and-direction scheme phase A carries the step (rising edges only) and phase B gives the direction. The outputs are the position, the direction of the last step, a one-cycle wrap pulse and a flag that records which way the last wrap went. All configuration inputs are static; they are changed only while reset is held, except for the enable.

Top module: `qdec_frontend`

## Requirements
- R1: While reset is held and in the first cycle after it, `pos_count` is 0 and `dir_up`, `wrap_pulse` and `wrap_up` are 0.
- R2: A phase level change is accepted only after the synchronized input has differed from the accepted level for T = max(4 × filter length, 1) consecutive cycles; a pulse shorter than T cycles is discarded. An accepted change moves `pos_count` on clock edge 3+T counted from the first edge that samples the new level (edge 1).
- R3: Phase A uses `cfg_filt_a` and phase B uses `cfg_filt_b`, each independently of the other.
- R4: `cfg_inv_a` / `cfg_inv_b` equal to 1 invert the phase before decoding; a steady input after reset produces no step whatever its polarity setting.
- R5: With `cfg_mode` = 0 (phase-encoded), the decoded state {A,B} stepping 00→10→11→01→00 counts up by one per change, and the reverse order counts down by one per change.
- R6: With `cfg_mode` = 0, a change in which both decoded phases change in the same cycle leaves `pos_count` unchanged.
- R7: With `cfg_mode` = 1 (step-and-direction), each rising edge of decoded A counts up when decoded B is 1 and down when it is 0; falling edges of A and any edge of B do not count.
- R8: An up step at `pos_count` ≥ `cfg_modulo` sets `pos_count` to 0, raises `wrap_pulse` for exactly one cycle and sets `wrap_up` to 1.
- R9: A down step at `pos_count` = 0 sets `pos_count` to `cfg_modulo`, raises `wrap_pulse` for exactly one cycle and sets `wrap_up` to 0.
- R10: While `cfg_enable` is 0 the position does not move; phase history is still tracked, so raising the enable creates no step.
- R11: `dir_up` holds the direction of the most recent step (1 = up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_a_in | input | 1 | Asynchronous phase A |
| phase_b_in | input | 1 | Asynchronous phase B |
| cfg_enable | input | 1 | Allows steps to move the position |
| cfg_mode | input | 1 | 0 = phase-encoded, 1 = step-and-direction |
| cfg_filt_a | input | 4 | Phase A filter length (units of 4 cycles) |
| cfg_filt_b | input | 4 | Phase B filter length (units of 4 cycles) |
| cfg_inv_a | input | 1 | Invert phase A |
| cfg_inv_b | input | 1 | Invert phase B |
| cfg_modulo | input | 16 | Largest position value before wrap |
| pos_count | output | 16 | Position counter |
| dir_up | output | 1 | Direction of last step |
| wrap_pulse | output | 1 | One-cycle pulse on wrap in either direction |
| wrap_up | output | 1 | Direction of the last wrap (1 = up) |

## Verification
A wrap and a reversal of direction can land on the same step: a reverse sweep that starts at position 0 makes the first down step both flip `dir_up` and wrap to the modulo value. The bench provokes this by running full forward then reverse Gray sweeps for several modulo values, including 0 where every step wraps, and judges each step against an arithmetic model of position, direction, wrap count and wrap direction. The second overlap, both phases accepted in one cycle, is provoked by flipping both inputs together and judged by an unchanged position followed by a correct next step.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

    typedef enum logic {
        DEC_QUAD    = 1'b0,
        DEC_STEPDIR = 1'b1
    } dec_mode_e;

    typedef struct packed {
        logic step;
        logic up;
    } step_t;

    // Direction of a single-phase change in the phase-encoded scheme,
    // judged on the new phase levels.
    function automatic logic quad_dir_up(input logic a_changed,
                                         input logic a_now,
                                         input logic b_now);
        return a_changed ? (a_now ^ b_now) : ~(a_now ^ b_now);
    endfunction

endpackage

// File: rtl/qdec_phase_filter.sv
module qdec_phase_filter #(
    parameter int FILT_W      = 4,
    parameter int FILT_SCALE  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              raw_in,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              invert,
    output logic              phase_out
);
    localparam int RUN_W = FILT_W + $clog2(FILT_SCALE) + 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sample;
    logic                   flt_q;
    logic [RUN_W-1:0]       run_q;
    logic [RUN_W-1:0]       thr;

    assign sample = sync_q[SYNC_STAGES-1];
    assign thr    = (RUN_W'(filt_len) * RUN_W'(FILT_SCALE) == '0)
                    ? RUN_W'(1) : RUN_W'(filt_len) * RUN_W'(FILT_SCALE);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_q <= 1'b0;
            run_q <= '0;
        end else if (sample == flt_q) begin
            run_q <= '0;
        end else if (run_q + RUN_W'(1) >= thr) begin
            flt_q <= sample;
            run_q <= '0;
        end else begin
            run_q <= run_q + RUN_W'(1);
        end
    end

    assign phase_out = flt_q ^ invert;

    AST_FILT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        !$stable(flt_q) |-> $past(sample != flt_q)); // R2

    AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
        (run_q != '0) |-> (sample != flt_q) || ($past(sample) != flt_q)); // R2

endmodule

// File: rtl/qdec_step_decode.sv
module qdec_step_decode
    import qdec_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  dec_mode_e mode,
    input  logic      rst_a,
    input  logic      rst_b,
    input  logic      a_now,
    input  logic      b_now,
    output step_t     step
);
    logic a_prev, b_prev;
    logic a_chg, b_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_prev <= rst_a;
            b_prev <= rst_b;
        end else begin
            a_prev <= a_now;
            b_prev <= b_now;
        end
    end

    assign a_chg = a_now ^ a_prev;
    assign b_chg = b_now ^ b_prev;

    always_comb begin
        step = '0;
        if (mode == DEC_QUAD) begin
            step.step = a_chg ^ b_chg;
            step.up   = quad_dir_up(a_chg, a_now, b_now);
        end else begin
            step.step = a_now & ~a_prev;
            step.up   = b_now;
        end
    end

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
    import qdec_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  step_t            step,
    input  logic [CNT_W-1:0] modulo,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             wrap_pulse,
    output logic             wrap_up
);
    logic [CNT_W-1:0] cnt_q;
    logic             dir_q, wrap_q, wup_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dir_q  <= 1'b0;
            wrap_q <= 1'b0;
            wup_q  <= 1'b0;
        end else begin
            wrap_q <= 1'b0;
            if (enable && step.step) begin
                dir_q <= step.up;
                if (step.up) begin
                    if (cnt_q >= modulo) begin
                        cnt_q  <= '0;
                        wrap_q <= 1'b1;
                        wup_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end else begin
                    if (cnt_q == '0) begin
                        cnt_q  <= modulo;
                        wrap_q <= 1'b1;
                        wup_q  <= 1'b0;
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
            end
        end
    end

    assign count      = cnt_q;
    assign dir_up     = dir_q;
    assign wrap_pulse = wrap_q;
    assign wrap_up    = wup_q;

    AST_STEP_DELTA: assert property (@(posedge clk) disable iff (rst)
        (!$stable(cnt_q) && !wrap_q) |->
        ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == $past(cnt_q) - CNT_W'(1)))); // R5

    AST_WRAP_UP: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && wup_q) |-> (cnt_q == '0)); // R8

    AST_WRAP_DN: assert property (@(posedge clk) disable iff (rst)
        (wrap_q && !wup_q) |-> (cnt_q == modulo)); // R9

    AST_HOLD_DIS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(cnt_q)); // R10

    AST_WRAP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wrap_q |=> !wrap_q || $past(enable && step.step)); // R8

endmodule

// File: rtl/qdec_frontend.sv
module qdec_frontend
    import qdec_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FILT_W      = 4,
    parameter int FILT_SCALE  = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              phase_a_in,
    input  logic              phase_b_in,
    input  logic              cfg_enable,
    input  logic              cfg_mode,
    input  logic [FILT_W-1:0] cfg_filt_a,
    input  logic [FILT_W-1:0] cfg_filt_b,
    input  logic              cfg_inv_a,
    input  logic              cfg_inv_b,
    input  logic [CNT_W-1:0]  cfg_modulo,
    output logic [CNT_W-1:0]  pos_count,
    output logic              dir_up,
    output logic              wrap_pulse,
    output logic              wrap_up
);
    localparam int NPH = 2;

    logic              raw_arr [NPH];
    logic [FILT_W-1:0] len_arr [NPH];
    logic              inv_arr [NPH];
    logic              ph_arr  [NPH];
    step_t             step;
    dec_mode_e         mode;

    assign raw_arr[0] = phase_a_in;
    assign raw_arr[1] = phase_b_in;
    assign len_arr[0] = cfg_filt_a;
    assign len_arr[1] = cfg_filt_b;
    assign inv_arr[0] = cfg_inv_a;
    assign inv_arr[1] = cfg_inv_b;
    assign mode       = dec_mode_e'(cfg_mode);

    for (genvar g = 0; g < NPH; g++) begin : g_phase
        qdec_phase_filter #(
            .FILT_W      (FILT_W),
            .FILT_SCALE  (FILT_SCALE),
            .SYNC_STAGES (SYNC_STAGES)
        ) u_filt (
            .clk       (clk),
            .rst       (rst),
            .raw_in    (raw_arr[g]),
            .filt_len  (len_arr[g]),
            .invert    (inv_arr[g]),
            .phase_out (ph_arr[g])
        );
    end

    qdec_step_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .mode  (mode),
        .rst_a (cfg_inv_a),
        .rst_b (cfg_inv_b),
        .a_now (ph_arr[0]),
        .b_now (ph_arr[1]),
        .step  (step)
    );

    qdec_pos_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .enable     (cfg_enable),
        .step       (step),
        .modulo     (cfg_modulo),
        .count      (pos_count),
        .dir_up     (dir_up),
        .wrap_pulse (wrap_pulse),
        .wrap_up    (wrap_up)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> (pos_count == '0) && !wrap_pulse && !dir_up); // R1

endmodule

// File: tb/tb_qdec_frontend.sv
module tb_qdec_frontend;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pa = 1'b0, pb = 1'b0;
    logic        en = 1'b1, mode = 1'b0;
    logic [3:0]  fa = '0, fb = '0;
    logic        ia = 1'b0, ib = 1'b0;
    logic [15:0] modv = 16'd5;
    logic [15:0] pos;
    logic        dir, wrp, wup;

    int checks = 0, failures = 0;
    int wrap_seen = 0;
    int exp_cnt = 0;
    int exp_wrap = 0;
    bit exp_dir = 0, exp_wup = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (!rst && wrp) wrap_seen++;

    qdec_frontend dut (
        .clk(clk), .rst(rst), .phase_a_in(pa), .phase_b_in(pb),
        .cfg_enable(en), .cfg_mode(mode), .cfg_filt_a(fa), .cfg_filt_b(fb),
        .cfg_inv_a(ia), .cfg_inv_b(ib), .cfg_modulo(modv),
        .pos_count(pos), .dir_up(dir), .wrap_pulse(wrp), .wrap_up(wup)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic restart(input bit m, input int la, input int lb,
                           input bit xa, input bit xb, input int mv);
        @(negedge clk);
        rst = 1'b1; mode = m; fa = 4'(la); fb = 4'(lb);
        ia = xa; ib = xb; modv = 16'(mv); pa = 1'b0; pb = 1'b0; en = 1'b1;
        wait_edges(3);
        rst = 1'b0;
        exp_cnt = 0; exp_dir = 0; exp_wup = 0;
    endtask

    task automatic model_step(input bit up);
        exp_wrap = 0;
        exp_dir = up;
        if (up) begin
            if (exp_cnt >= int'(modv)) begin exp_cnt = 0; exp_wrap = 1; exp_wup = 1; end
            else exp_cnt++;
        end else begin
            if (exp_cnt == 0) begin exp_cnt = int'(modv); exp_wrap = 1; exp_wup = 0; end
            else exp_cnt--;
        end
    endtask

    // Drive new raw levels, let the step settle, compare with model.
    task automatic move(input bit a, input bit b, input int stepping, input bit up,
                        input string req);
        int base;
        base = wrap_seen;
        if (stepping != 0) model_step(up); else exp_wrap = 0;
        pa = a; pb = b;
        wait_edges(6);
        check(int'(pos) == exp_cnt, req, int'(pos), exp_cnt);
        check(wrap_seen - base == exp_wrap, req, wrap_seen - base, exp_wrap);
        check(dir == exp_dir, "R11", int'(dir), int'(exp_dir));
        if (exp_wrap != 0) check(wup == exp_wup, exp_wup ? "R8" : "R9", int'(wup), int'(exp_wup));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
        $finish;
    end

    initial begin : main
        bit gray_a [4];
        bit gray_b [4];
        int mods [3];
        gray_a = '{0, 1, 1, 0};
        gray_b = '{0, 0, 1, 1};
        mods = '{0, 3, 5};

        // R1 reset state
        @(negedge clk);
        check(pos == 0 && !dir && !wrp && !wup, "R1", int'(pos), 0);
        restart(0, 0, 0, 0, 0, 5);
        check(pos == 0 && !dir && !wrp && !wup, "R1", int'(pos), 0);

        // R5 R8 R9 R11: forward then reverse Gray sweeps for several modulo values
        for (int mi = 0; mi < 3; mi++) begin
            int idx;
            restart(0, 0, 0, 0, 0, mods[mi]);
            idx = 0;
            for (int s = 0; s < 14; s++) begin
                idx = (idx + 1) % 4;
                move(gray_a[idx], gray_b[idx], 1, 1'b1, "R5 fwd");
            end
            for (int s = 0; s < 16; s++) begin
                idx = (idx + 3) % 4;
                move(gray_a[idx], gray_b[idx], 1, 1'b0, "R5 rev");
            end
        end

        // R6: both phases change together -> ignored, then decoding resumes
        restart(0, 0, 0, 0, 0, 9);
        move(1, 1, 0, 1'b0, "R6 double change");
        move(0, 1, 1, 1'b1, "R6 resume");

        // R10: disabled holds position, enabling creates no step
        restart(0, 0, 0, 0, 0, 9);
        en = 1'b0;
        move(1, 0, 0, 1'b0, "R10 disabled");
        en = 1'b1;
        wait_edges(4);
        check(pos == 0, "R10 enable edge", int'(pos), 0);
        move(1, 1, 1, 1'b1, "R10 after enable");

        // R7: step-and-direction mode, modulo 4
        restart(1, 0, 0, 0, 0, 4);
        move(0, 1, 0, 1'b0, "R7 B edge");
        for (int k = 0; k < 6; k++) begin
            move(1, 1, 1, 1'b1, "R7 rise up");
            move(0, 1, 0, 1'b0, "R7 fall");
        end
        move(0, 0, 0, 1'b0, "R7 B fall");
        for (int k = 0; k < 6; k++) begin
            move(1, 0, 1, 1'b0, "R7 rise down");
            move(0, 0, 0, 1'b0, "R7 fall");
        end

        // R4: both phases inverted; steady zero inputs decode as high
        restart(1, 0, 0, 1, 1, 7);
        wait_edges(6);
        check(pos == 0 && !wrp, "R4 no spurious step", int'(pos), 0);
        move(1, 0, 0, 1'b0, "R4 inverted fall");
        move(0, 0, 1, 1'b1, "R4 inverted rise B-high");
        move(0, 1, 0, 1'b0, "R4 B inverted low");
        move(1, 1, 0, 1'b0, "R4 inverted fall");
        move(0, 1, 1, 1'b0, "R4 inverted rise B-low");

        // R2: pulse width against filter length 2 (T = 8)
        restart(1, 2, 0, 0, 0, 9);
        pb = 1'b1;
        wait_edges(6);
        pa = 1'b1; repeat (7) @(posedge clk); @(negedge clk); pa = 1'b0;
        wait_edges(14);
        check(pos == 0, "R2 short pulse rejected", int'(pos), 0);
        pa = 1'b1; repeat (8) @(posedge clk); @(negedge clk); pa = 1'b0;
        wait_edges(14);
        check(pos == 1, "R2 pulse accepted", int'(pos), 1);

        // R2 R3: exact latency, B length 1 (T=4), A length 3 (T=12)
        restart(0, 3, 1, 0, 0, 9);
        pb = 1'b1;
        wait_edges(6);
        check(pos == 0, "R3 B not yet", int'(pos), 0);
        wait_edges(1);
        check(pos == 9, "R3 B latency", int'(pos), 9);
        pa = 1'b1;
        wait_edges(14);
        check(pos == 9, "R3 A not yet", int'(pos), 9);
        wait_edges(1);
        check(pos == 8, "R3 A latency", int'(pos), 8);

        // R2: zero length gives T = 1
        restart(0, 0, 0, 0, 0, 9);
        pa = 1'b1;
        wait_edges(3);
        check(pos == 0, "R2 len0 not yet", int'(pos), 0);
        wait_edges(1);
        check(pos == 1, "R2 len0 latency", int'(pos), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule